// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the timing and counting logic of a dual-slope integrating converter. The analog parts sit outside it: the integrator, its three switches and the zero-crossing comparator. After an accepted start, the block first holds the discharge switch closed to empty the integrator. It then connects the unknown input for a fixed number of clocks equal to full scale. Finally it connects a reference of opposite polarity and counts clocks until the comparator reports that the integrator output has come back through ground.

The run-down count is proportional to the unknown input, and the block reports it as the result. The comparator arrives asynchronously and is synchronized, and the delay added by the synchronizer is removed from the count. A conversion that does not trip within full scale stops at a fixed limit and reports an overrange. Every switch change passes through one cycle with all switches open. A single-cycle done pulse marks the end of each conversion.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and after it is released, all three switch outputs, `done_o`, `ovr_o` and `result_o` are 0.
- R2: A start seen in the idle state closes the discharge switch (`sw_zero_o`) in the next cycle, for exactly ZERO_CYC consecutive cycles (default 16).
- R3: The input switch (`sw_in_o`) is closed for exactly 2^CNT_W consecutive cycles in each conversion (default 4096).
- R4: At most one switch output is high in any cycle. Any change from one closed switch to another passes through exactly one cycle with all switches open, so the order is discharge, gap, input, gap, reference.
- R5: `cmp_i` = 1 means the integrator has not yet crossed ground, and 0 means it has crossed. The reference switch stays closed until a low value has passed the SYNC_STAGES-flop synchronizer (default 2), and it opens in the cycle after that.
- R6: If `cmp_i` is high for the first N cycles of the reference phase and low from then on, with N < 2^CNT_W, `result_o` is N. If `cmp_i` is already low when the reference phase begins, `result_o` is 0.
- R7: If the comparator has not tripped after 2^CNT_W counts, net of the synchronizer delay, the block ends the conversion with `result_o` all ones and `ovr_o` = 1. Otherwise `ovr_o` = 0.
- R8: `done_o` is high for exactly one cycle, in the cycle after the reference switch opens. The block is idle in the cycle after that.
- R9: `result_o` and `ovr_o` take their new values in the done cycle. They hold those values until the next accepted start, which clears both to 0 in the cycle the discharge switch closes.
- R10: A start asserted in any state other than idle, including the done cycle, is ignored and does not change the switch sequence or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a conversion (taken only when idle) |
| cmp_i | input | 1 | Asynchronous comparator: 1 = not yet crossed ground |
| sw_zero_o | output | 1 | Close the integrator discharge switch |
| sw_in_o | output | 1 | Close the unknown-input switch |
| sw_ref_o | output | 1 | Close the opposite-polarity reference switch |
| result_o | output | CNT_W | Run-down count of the last conversion |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| ovr_o | output | 1 | Last conversion did not trip within full scale |

## Verification
The bench builds the block with CNT_W = 5 and ZERO_CYC = 4, and keeps the synchronizer at its default depth of 2. With these values one conversion takes under a hundred cycles, so a single run can cover zero input, small counts, the largest count that does not overflow, the first count that does, and counts well past the limit. The comparator model follows the cycles in which the reference switch is closed. The bench can therefore check the latency correction and the exact cycle at which the block gives up on a conversion that never trips.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ZERO  = 3'd1,
    ST_GAP_A = 3'd2,
    ST_INTEG = 3'd3,
    ST_GAP_B = 3'd4,
    ST_RUNDN = 3'd5,
    ST_DONE  = 3'd6
  } dsadc_state_e;
endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dsadc_timer.sv
module dsadc_timer #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)     cnt_d = '0;
    else if (en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dsadc_fsm.sv
module dsadc_fsm
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int ZERO_CYC    = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CW          = CNT_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          trip_i,
  input  logic [CW-1:0] tcnt_i,
  output logic          tmr_clr_o,
  output logic          tmr_en_o,
  output logic          accept_o,
  output logic          cap_o,
  output logic          cap_ovr_o,
  output dsadc_state_e  state_o
);
  localparam int FS = 1 << CNT_W;
  localparam logic [CW-1:0] ZERO_LAST = CW'(ZERO_CYC - 1);
  localparam logic [CW-1:0] INT_LAST  = CW'(FS - 1);
  localparam logic [CW-1:0] RUN_LIMIT = CW'(FS - 1 + SYNC_STAGES);

  dsadc_state_e state_d, state_q;

  always_comb begin
    state_d   = state_q;
    accept_o  = 1'b0;
    cap_o     = 1'b0;
    cap_ovr_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_ZERO;
          accept_o = 1'b1;
        end
      end
      ST_ZERO:  if (tcnt_i == ZERO_LAST) state_d = ST_GAP_A;
      ST_GAP_A: state_d = ST_INTEG;
      ST_INTEG: if (tcnt_i == INT_LAST) state_d = ST_GAP_B;
      ST_GAP_B: state_d = ST_RUNDN;
      ST_RUNDN: begin
        if (trip_i) begin
          cap_o   = 1'b1;
          state_d = ST_DONE;
        end else if (tcnt_i == RUN_LIMIT) begin
          cap_o     = 1'b1;
          cap_ovr_o = 1'b1;
          state_d   = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tmr_clr_o = (state_d != state_q);
  assign tmr_en_o  = (state_q == ST_ZERO) || (state_q == ST_INTEG) ||
                     (state_q == ST_RUNDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int ZERO_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sw_zero_o,
  output logic             sw_in_o,
  output logic             sw_ref_o,
  output logic [CNT_W-1:0] result_o,
  output logic             done_o,
  output logic             ovr_o
);
  localparam int CW = CNT_W + 2;

  logic          cmp_s;
  logic          tmr_clr, tmr_en, accept, cap, cap_ovr;
  logic [CW-1:0] tcnt;
  dsadc_state_e  state;

  dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
  );

  dsadc_timer #(.W(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(tmr_clr), .en_i(tmr_en), .cnt_o(tcnt)
  );

  dsadc_fsm #(
    .CNT_W(CNT_W), .ZERO_CYC(ZERO_CYC), .SYNC_STAGES(SYNC_STAGES), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trip_i(!cmp_s),
    .tcnt_i(tcnt), .tmr_clr_o(tmr_clr), .tmr_en_o(tmr_en),
    .accept_o(accept), .cap_o(cap), .cap_ovr_o(cap_ovr), .state_o(state)
  );

  // Result capture: synchronizer delay removed, clamped at zero.
  logic [CNT_W-1:0] res_d, res_q;
  logic             ovr_d, ovr_q, res_en;

  always_comb begin
    res_en = accept | cap;
    res_d  = '0;
    ovr_d  = 1'b0;
    if (cap) begin
      ovr_d = cap_ovr;
      if (cap_ovr)                         res_d = '1;
      else if (tcnt < CW'(SYNC_STAGES))    res_d = '0;
      else                                 res_d = CNT_W'(tcnt - CW'(SYNC_STAGES));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      ovr_q <= 1'b0;
    end else if (res_en) begin
      res_q <= res_d;
      ovr_q <= ovr_d;
    end
  end

  assign sw_zero_o = (state == ST_ZERO);
  assign sw_in_o   = (state == ST_INTEG);
  assign sw_ref_o  = (state == ST_RUNDN);
  assign done_o    = (state == ST_DONE);
  assign result_o  = res_q;
  assign ovr_o     = ovr_q;
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int CNT_W    = 12,
  parameter int ZERO_CYC = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_zero_o,
  input logic             sw_in_o,
  input logic             sw_ref_o,
  input logic [CNT_W-1:0] result_o,
  input logic             done_o,
  input logic             ovr_o
);
  localparam int CW = CNT_W + 2;
  localparam int FS = 1 << CNT_W;

  logic [2:0]    sw_now;
  logic [CW-1:0] in_run_q, zero_run_q;

  assign sw_now = {sw_zero_o, sw_in_o, sw_ref_o};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run_q   <= '0;
      zero_run_q <= '0;
    end else begin
      in_run_q   <= sw_in_o   ? in_run_q + 1'b1   : '0;
      zero_run_q <= sw_zero_o ? zero_run_q + 1'b1 : '0;
    end
  end

  p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_zero_o) |-> zero_run_q == CW'(ZERO_CYC));

  p_integ_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_in_o) |-> in_run_q == CW'(FS));

  p_one_switch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_now));

  p_dead_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_now != 3'b000) |=> (sw_now == $past(sw_now)) || (sw_now == 3'b000));

  p_ovr_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (result_o == {CNT_W{1'b1}}));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sw_ref_o) |-> done_o);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> (done_o || $rose(sw_zero_o)));
endmodule

bind dsadc_seq dsadc_seq_chk #(.CNT_W(CNT_W), .ZERO_CYC(ZERO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_zero_o(sw_zero_o), .sw_in_o(sw_in_o),
  .sw_ref_o(sw_ref_o), .result_o(result_o), .done_o(done_o), .ovr_o(ovr_o)
);

// File: tb/tb_dsadc_seq.sv
`timescale 1ns/1ps
module tb_dsadc_seq;
  localparam int CNT_W = 5;
  localparam int ZC    = 4;
  localparam int SY    = 2;
  localparam int FS    = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cmp_i = 1'b0;
  logic sw_zero_o, sw_in_o, sw_ref_o, done_o, ovr_o;
  logic [CNT_W-1:0] result_o;

  always #10 clk = ~clk;

  dsadc_seq #(.CNT_W(CNT_W), .ZERO_CYC(ZC), .SYNC_STAGES(SY)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .sw_zero_o(sw_zero_o), .sw_in_o(sw_in_o), .sw_ref_o(sw_ref_o),
    .result_o(result_o), .done_o(done_o), .ovr_o(ovr_o)
  );

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  int nval = 0;
  int ref_seen = 0;

  // Behavioural reference: phase 0 idle,1 discharge,2 gap,3 input,4 gap,5 reference,6 done
  int ph = 0, t = 0, mres = 0;
  bit movr = 0;
  bit m1 = 0, m2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; t = 0; mres = 0; movr = 0; m1 = 0; m2 = 0;
    end else begin
      case (ph)
        0: if (start_i) begin ph = 1; t = 0; mres = 0; movr = 0; end
        1: if (t == ZC - 1) begin ph = 2; t = 0; end else t++;
        2: begin ph = 3; t = 0; end
        3: if (t == FS - 1) begin ph = 4; t = 0; end else t++;
        4: begin ph = 5; t = 0; end
        5: begin
          if (!m2) begin
            mres = (t < SY) ? 0 : t - SY; ph = 6; t = 0;
          end else if (t == FS - 1 + SY) begin
            mres = FS - 1; movr = 1; ph = 6; t = 0;
          end else t++;
        end
        default: ph = 0;
      endcase
      m2 = m1;
      m1 = cmp_i;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(sw_zero_o == (ph == 1), "R2 sw_zero_o", sw_zero_o, ph == 1);
    check(sw_in_o   == (ph == 3), "R3 sw_in_o",   sw_in_o,   ph == 3);
    check(sw_ref_o  == (ph == 5), "R5 sw_ref_o",  sw_ref_o,  ph == 5);
    check(done_o    == (ph == 6), "R8 done_o",    done_o,    ph == 6);
    check(result_o  == CNT_W'(mres), "R6 result_o", result_o, mres);
    check(ovr_o     == movr,      "R7 ovr_o",     ovr_o,     movr);
    check($countones({sw_zero_o, sw_in_o, sw_ref_o}) <= 1, "R4 one switch",
          $countones({sw_zero_o, sw_in_o, sw_ref_o}), 1);
    // Comparator model: high until the reference has been in for nval cycles
    if (sw_in_o) ref_seen = 0;
    cmp_i = (ref_seen < nval);
    if (sw_ref_o) ref_seen++;
  endtask

  task automatic convert(input int n, input int poke);
    int expv;
    bit seen;
    nval = n;
    seen = 0;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (k == poke) start_i = 1'b1;   // R10: start while busy
      tick();
      start_i = 1'b0;
      if (done_o) begin seen = 1; break; end
    end
    check(seen, "R8 done seen", seen, 1);
    expv = (n >= FS) ? FS - 1 : n;
    check(result_o == CNT_W'(expv), "R6 result vs run-down length", result_o, expv);
    check(ovr_o == (n >= FS), "R7 overrange flag", ovr_o, n >= FS);
    // R10: start in the done cycle is ignored
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check(!sw_zero_o, "R10 start in done ignored", sw_zero_o, 0);
    for (int k = 0; k < 5; k++) begin
      tick();
      check(result_o == CNT_W'(expv), "R9 result holds", result_o, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nfail++;
      $display("FAIL R8 watchdog: actual no completion, expected done within limit");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    check({sw_zero_o, sw_in_o, sw_ref_o, done_o, ovr_o} == 5'b0, "R1 reset outputs",
          {sw_zero_o, sw_in_o, sw_ref_o, done_o, ovr_o}, 0);
    check(result_o == '0, "R1 reset result", result_o, 0);
    rst_n = 1'b1;
    tick();
    tick();
    check(!sw_zero_o && !done_o, "R1 idle after reset", sw_zero_o, 0);
    convert(10, -1);
    convert(0, -1);
    convert(1, 3);
    convert(FS - 2, 20);
    convert(FS - 1, -1);
    convert(FS, 50);
    convert(FS + 7, -1);
    convert(3, 8);
    // R9: accepted start clears the overrange result
    convert(FS + 1, -1);
    nval = 5;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check(sw_zero_o, "R2 discharge after start", sw_zero_o, 1);
    check(result_o == '0 && !ovr_o, "R9 cleared at start", result_o, 0);
    for (int k = 0; k < 120; k++) tick();
    check(result_o == CNT_W'(5), "R6 final result", result_o, 5);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule